// File: doc/BRIEF.md
# SDRAM Command Sequencer with Refresh

This block sits between a simple host request port and a single-rank, four-bank, 64-bit synchronous DRAM clocked at 10 ns with read latency 2. A host request carries a linear word address, a write flag, write data and byte enables. The controller splits the address into bank, row and column. It then drives the memory's command pins through a closed-row sequence: open the row, access one word, close the row. Read data comes back on a one-cycle response strobe.

After reset the block runs the power-up sequence on its own. It waits a programmable number of cycles, closes every bank, performs two refresh cycles and programs the mode word. A free-running timer then asks for one refresh per interval. That request takes precedence over host traffic. Every minimum spacing is held by a cycle counter whose load value is derived from a nanosecond parameter, rounded up to whole clocks.

Top module: `sdram_ctrl`

## Requirements
- R1: After reset, no command other than NOP appears for INIT_CYCLES cycles. Then, in order: PRECHARGE with A10=1, two AUTO REFRESH, and MODE REGISTER SET with BA=0 and A=0x020 (burst 1, sequential, latency 2). `req_ready` rises the cycle after the mode-register command. During reset `req_ready`, `rsp_valid` are 0 and `sd_cs_n` is 1.
- R2: With `sd_cs_n` low, {ras_n,cas_n,we_n} encodes ACTIVE=011, READ=101, WRITE=100, PRECHARGE=010, AUTO REFRESH=001, MODE SET=000, NOP=111.
- R3: Address bits [24:23] select the bank on BA. Bits [22:10] are the row, driven on A with ACTIVE. Bits [9:0] are the column, driven on A[9:0] with READ/WRITE.
- R4: READ/WRITE appears exactly 2 cycles after its ACTIVE, with a NOP between them and A10=0.
- R5: Per bank, PRECHARGE comes at least 5 cycles after ACTIVE and at least 2 cycles after WRITE. ACTIVE comes at least 2 cycles after PRECHARGE, at least 7 cycles after the previous ACTIVE, and only to a closed bank.
- R6: In the WRITE cycle `sd_dq_oe`=1 and `sd_dq_out` carries the write data. `sd_dqm[i]` = NOT `req_be[i]`, so a set DQM bit masks byte i (bits 8i+7..8i) in that same cycle.
- R7: `rsp_valid` pulses for one cycle, 3 cycles after READ appears on the pins. It carries the word that was on `sd_dq_in` 2 cycles after READ.
- R8: Periodic AUTO REFRESH commands are spaced REF_NS/CLK_NS cycles apart (780 by default), within ±8 cycles, even under continuous host load.
- R9: No command follows AUTO REFRESH for 7 cycles or MODE SET for 2 cycles. AUTO REFRESH and MODE SET are issued only when every bank is closed.
- R10: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. Its ACTIVE appears in the next cycle, and only one request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 ns |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | Linear word address {bank,row,col} |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables, bit i for byte i |
| rsp_valid | output | 1 | Read data valid strobe |
| rsp_rdata | output | 64 | Read data |
| sd_cke | output | 1 | Clock enable, high out of reset |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write strobe |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 13 | Row/column/mode address |
| sd_dqm | output | 8 | Data byte masks |
| sd_dq_out | output | 64 | Write data to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 64 | Read data from memory |

## Verification
ACTIVE is due on the pins one cycle after the handshake edge and READ/WRITE two cycles later. The read response is due three cycles after READ, and the first PRECHARGE after reset comes exactly INIT_CYCLES cycles after release. The request tasks sample on falling edges and count those edges from the handshake, so each pin is compared in the one cycle it is due. The cycle before the response is also checked to be quiet. A behavioural memory in the bench decodes every command at the falling edge. It checks each gap against its cycle minimum and returns read data at exactly the second edge after READ, so a wrong latency shows up as wrong data.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

    // {ras_n, cas_n, we_n} with chip select low
    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef enum logic [2:0] {
        ST_PWR,
        ST_IREF1,
        ST_IREF2,
        ST_IMRS,
        ST_IDLE,
        ST_RW,
        ST_PRE
    } state_e;

    // Round a nanosecond limit up to whole clock cycles
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    always_comb begin
        col  = addr[COL_W-1:0];
        row  = addr[COL_W +: ROW_W];
        bank = addr[ADDR_W-1 -: BANK_W];
    end
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int PERIOD = 780,
    localparam int CNT_W = $clog2(PERIOD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic due
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             due;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (ack) t_d.due = 1'b0;
        if (!run) begin
            t_d.cnt = CNT_W'(PERIOD - 1);
        end else if (t_q.cnt == '0) begin
            t_d.cnt = CNT_W'(PERIOD - 1);
            t_d.due = 1'b1;
        end else begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.cnt <= CNT_W'(PERIOD - 1);
            t_q.due <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign due = t_q.due;

    // R8
    due_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !ack) |=> due);
    // R8
    ack_when_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> due);
endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
    import sdram_ctrl_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int T_RCD_NS    = 20,
    parameter int T_RP_NS     = 20,
    parameter int T_RAS_NS    = 50,
    parameter int T_RC_NS     = 70,
    parameter int T_WR_CYC    = 2,
    parameter int T_MRD_CYC   = 2,
    parameter int CAS_LAT     = 2,
    parameter int REF_NS      = 7800,
    parameter int INIT_CYCLES = 20000,
    parameter int DATA_W      = 64,
    parameter int BANK_W      = 2,
    parameter int ROW_W       = 13,
    parameter int COL_W       = 10,
    localparam int ADDR_W     = BANK_W + ROW_W + COL_W,
    localparam int BE_W       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_a,
    output logic [BE_W-1:0]   sd_dqm,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);
    localparam int T_RCD   = ns_to_cyc(T_RCD_NS, CLK_NS);
    localparam int T_RP    = ns_to_cyc(T_RP_NS, CLK_NS);
    localparam int T_RAS   = ns_to_cyc(T_RAS_NS, CLK_NS);
    localparam int T_RC    = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int REF_CYC = REF_NS / CLK_NS;
    // access-to-close gap covers row-active time, write recovery and row cycle
    localparam int RW2PRE  = imax(imax(T_RAS - T_RCD, T_WR_CYC), T_RC - T_RCD - T_RP);
    localparam int CW      = $clog2(INIT_CYCLES + T_RC + RW2PRE + 2);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

    typedef struct packed {
        state_e            st;
        logic [CW-1:0]     wait_n;
        cmd_e              cmd;
        logic              cs_n;
        logic              cke;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  a;
        logic [BE_W-1:0]   dqm;
        logic [DATA_W-1:0] dq;
        logic              oe;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic [CAS_LAT:0]  rpipe;
        logic              rsp_v;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [BANK_W-1:0] in_bank;
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;
    logic              ref_due, ref_ack, ref_run;

    sdram_addr_split #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) split_i (
        .addr(req_addr), .bank(in_bank), .row(in_row), .col(in_col)
    );

    sdram_refresh_timer #(.PERIOD(REF_CYC)) refresh_i (
        .clk(clk), .rst_n(rst_n), .run(ref_run), .ack(ref_ack), .due(ref_due)
    );

    assign ref_run   = !(r_q.st inside {ST_PWR, ST_IREF1, ST_IREF2, ST_IMRS});
    assign req_ready = (r_q.st == ST_IDLE) && (r_q.wait_n == '0) && !ref_due;

    always_comb begin
        r_d       = r_q;
        ref_ack   = 1'b0;
        r_d.cmd   = CMD_NOP;
        r_d.cs_n  = 1'b0;
        r_d.cke   = 1'b1;
        r_d.oe    = 1'b0;
        r_d.dqm   = '0;
        r_d.rsp_v = 1'b0;
        r_d.rpipe = {r_q.rpipe[CAS_LAT-1:0], 1'b0};
        if (r_q.rpipe[CAS_LAT]) begin
            r_d.rsp_v = 1'b1;
            r_d.rdata = sd_dq_in;
        end
        if (r_q.wait_n != '0) begin
            r_d.wait_n = r_q.wait_n - 1'b1;
        end else begin
            case (r_q.st)
                ST_PWR: begin
                    r_d.cmd    = CMD_PRE;
                    r_d.a      = '0;
                    r_d.a[10]  = 1'b1;
                    r_d.st     = ST_IREF1;
                    r_d.wait_n = CW'(T_RP - 1);
                end
                ST_IREF1, ST_IREF2: begin
                    r_d.cmd    = CMD_REF;
                    r_d.st     = (r_q.st == ST_IREF1) ? ST_IREF2 : ST_IMRS;
                    r_d.wait_n = CW'(T_RC - 1);
                end
                ST_IMRS: begin
                    r_d.cmd    = CMD_MRS;
                    r_d.ba     = '0;
                    r_d.a      = MODE_WORD;
                    r_d.st     = ST_IDLE;
                    r_d.wait_n = CW'(T_MRD_CYC - 1);
                end
                ST_IDLE: begin
                    if (ref_due) begin
                        r_d.cmd    = CMD_REF;
                        ref_ack    = 1'b1;
                        r_d.wait_n = CW'(T_RC - 1);
                    end else if (req_valid) begin
                        r_d.cmd    = CMD_ACT;
                        r_d.ba     = in_bank;
                        r_d.a      = in_row;
                        r_d.bank   = in_bank;
                        r_d.col    = in_col;
                        r_d.we     = req_we;
                        r_d.wdata  = req_wdata;
                        r_d.be     = req_be;
                        r_d.st     = ST_RW;
                        r_d.wait_n = CW'(T_RCD - 1);
                    end
                end
                ST_RW: begin
                    r_d.cmd = r_q.we ? CMD_WR : CMD_RD;
                    r_d.ba  = r_q.bank;
                    r_d.a   = '0;
                    r_d.a[COL_W-1:0] = r_q.col;
                    if (r_q.we) begin
                        r_d.dq  = r_q.wdata;
                        r_d.oe  = 1'b1;
                        r_d.dqm = ~r_q.be;
                    end else begin
                        r_d.rpipe[0] = 1'b1;
                    end
                    r_d.st     = ST_PRE;
                    r_d.wait_n = CW'(RW2PRE - 1);
                end
                ST_PRE: begin
                    r_d.cmd    = CMD_PRE;
                    r_d.ba     = r_q.bank;
                    r_d.a      = '0;
                    r_d.st     = ST_IDLE;
                    r_d.wait_n = CW'(T_RP - 1);
                end
                default: r_d.st = ST_PWR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_PWR;
            r_q.wait_n <= CW'(INIT_CYCLES - 1);
            r_q.cmd    <= CMD_NOP;
            r_q.cs_n   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign {sd_ras_n, sd_cas_n, sd_we_n} = r_q.cmd;
    assign sd_cs_n   = r_q.cs_n;
    assign sd_cke    = r_q.cke;
    assign sd_ba     = r_q.ba;
    assign sd_a      = r_q.a;
    assign sd_dqm    = r_q.dqm;
    assign sd_dq_out = r_q.dq;
    assign sd_dq_oe  = r_q.oe;
    assign rsp_valid = r_q.rsp_v;
    assign rsp_rdata = r_q.rdata;

    // R4
    rw_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd inside {CMD_RD, CMD_WR}) |-> ($past(r_q.cmd, T_RCD) == CMD_ACT));
    // R5
    act_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_ACT) |-> ($past(r_q.cmd) != CMD_PRE));
    // R9
    mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_MRS) |=> (r_q.cmd == CMD_NOP));
    // R7
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(r_q.cmd, CAS_LAT + 1) == CMD_RD));
    // R10
    act_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (r_q.cmd == CMD_ACT));
    // R6
    oe_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (r_q.cmd == CMD_WR));
endmodule

// File: tb/sdram_ctrl_tb.sv
`timescale 1ns/1ps
module sdram_ctrl_tb_top;
    localparam int INIT_CYC = 100;
    localparam int REF_CYC  = 780;
    localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010,
                           C_ACT = 3'b011, C_WR = 3'b100, C_RD = 3'b101, C_NOP = 3'b111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [24:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_be = '0;
    logic req_ready, rsp_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [63:0] rsp_rdata, sd_dq_out;
    logic [63:0] sd_dq_in = '0;
    logic [1:0]  sd_ba;
    logic [12:0] sd_a;
    logic [7:0]  sd_dqm;

    always #5 clk = ~clk;

    sdram_ctrl #(.INIT_CYCLES(INIT_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    wire [2:0] pin_cmd = {sd_ras_n, sd_cas_n, sd_we_n};

    int checks = 0, errors = 0;
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural memory and command monitor ----------------
    logic [63:0] mem [logic [24:0]];
    logic [63:0] exp_mem [logic [24:0]];
    int cyc = 0;
    int last_act [4], last_pre [4];
    bit open_b [4];
    logic [12:0] orow [4];
    int last_wr = -1000, last_ref = -1000, last_mrs = -1000, last_act_any = -1000;
    int n_cmd = 0, ref_total = 0, rd_due = -1;
    logic [63:0] rd_val = '0;
    logic [2:0]  seq_cmd [5];
    logic [12:0] seq_a [5];
    logic [1:0]  seq_ba [5];
    int seq_cyc [5];

    initial begin
        for (int i = 0; i < 4; i++) begin
            last_act[i] = -1000; last_pre[i] = -1000; open_b[i] = 1'b0; orow[i] = '0;
        end
    end

    always @(negedge clk) begin
        cyc++;
        sd_dq_in = (rd_due == cyc) ? rd_val : 64'hDEAD_BEEF_0BAD_F00D;
        if (rst_n && !sd_cs_n && pin_cmd != C_NOP) begin
            if (n_cmd < 5) begin
                seq_cmd[n_cmd] = pin_cmd; seq_a[n_cmd] = sd_a;
                seq_ba[n_cmd] = sd_ba; seq_cyc[n_cmd] = cyc;
            end
            n_cmd++;
            chk(cyc - last_ref >= 7, "R9", "gap after refresh", 64'(cyc - last_ref), 7);
            chk(cyc - last_mrs >= 2, "R9", "gap after mode set", 64'(cyc - last_mrs), 2);
            case (pin_cmd)
                C_ACT: begin
                    chk(!open_b[sd_ba], "R5", "activate to open bank", 1, 0);
                    chk(cyc - last_pre[sd_ba] >= 2, "R5", "precharge->activate", 64'(cyc - last_pre[sd_ba]), 2);
                    chk(cyc - last_act[sd_ba] >= 7, "R5", "activate->activate same bank", 64'(cyc - last_act[sd_ba]), 7);
                    chk(cyc - last_act_any >= 2, "R5", "activate->activate any bank", 64'(cyc - last_act_any), 2);
                    open_b[sd_ba] = 1'b1; orow[sd_ba] = sd_a;
                    last_act[sd_ba] = cyc; last_act_any = cyc;
                end
                C_RD, C_WR: begin
                    logic [24:0] k;
                    chk(open_b[sd_ba], "R4", "access to closed bank", 0, 1);
                    chk(cyc - last_act[sd_ba] >= 2, "R4", "activate->access", 64'(cyc - last_act[sd_ba]), 2);
                    k = {sd_ba, orow[sd_ba], sd_a[9:0]};
                    if (pin_cmd == C_WR) begin
                        logic [63:0] w;
                        w = mem.exists(k) ? mem[k] : 64'h0;
                        for (int b = 0; b < 8; b++)
                            if (!sd_dqm[b]) w[b*8 +: 8] = sd_dq_out[b*8 +: 8];
                        mem[k] = w;
                        last_wr = cyc;
                    end else begin
                        rd_val = mem.exists(k) ? mem[k] : 64'h0;
                        rd_due = cyc + 2;
                    end
                end
                C_PRE: begin
                    if (sd_a[10]) begin
                        for (int b = 0; b < 4; b++) begin open_b[b] = 1'b0; last_pre[b] = cyc; end
                    end else begin
                        chk(cyc - last_act[sd_ba] >= 5, "R5", "activate->precharge", 64'(cyc - last_act[sd_ba]), 5);
                        chk(cyc - last_wr >= 2, "R5", "write->precharge", 64'(cyc - last_wr), 2);
                        open_b[sd_ba] = 1'b0; last_pre[sd_ba] = cyc;
                    end
                end
                C_REF: begin
                    chk(!(open_b[0] | open_b[1] | open_b[2] | open_b[3]), "R9", "refresh with open bank", 1, 0);
                    if (ref_total >= 3)
                        chk((cyc - last_ref >= REF_CYC - 8) && (cyc - last_ref <= REF_CYC + 8),
                            "R8", "refresh spacing", 64'(cyc - last_ref), REF_CYC);
                    ref_total++; last_ref = cyc;
                end
                C_MRS: begin
                    chk(!(open_b[0] | open_b[1] | open_b[2] | open_b[3]), "R9", "mode set with open bank", 1, 0);
                    last_mrs = cyc;
                end
                default: chk(0, "R2", "illegal command code", 64'(pin_cmd), 64'(C_NOP));
            endcase
        end
    end

    // ---------------- host request task ----------------
    task automatic host_req(input bit we, input logic [24:0] addr, input logic [63:0] wd,
                            input logic [7:0] be, output logic [63:0] rd);
        int guard = 0;
        rd = '0;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd; req_be = be;
        while (!req_ready && guard < 2000) begin @(negedge clk); guard++; end
        chk(guard < 2000, "R10", "request never accepted", 0, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(pin_cmd == C_ACT && !sd_cs_n, "R10", "activate after accept", 64'(pin_cmd), 64'(C_ACT));
        chk(sd_ba == addr[24:23], "R3", "bank on activate", 64'(sd_ba), 64'(addr[24:23]));
        chk(sd_a == addr[22:10], "R3", "row on activate", 64'(sd_a), 64'(addr[22:10]));
        @(negedge clk);
        chk(pin_cmd == C_NOP, "R4", "nop between activate and access", 64'(pin_cmd), 64'(C_NOP));
        @(negedge clk);
        chk(pin_cmd == (we ? C_WR : C_RD), "R4", "access command", 64'(pin_cmd), 64'(we ? C_WR : C_RD));
        chk(sd_a[9:0] == addr[9:0], "R3", "column on access", 64'(sd_a[9:0]), 64'(addr[9:0]));
        chk(sd_a[10] == 1'b0, "R4", "A10 on access", 64'(sd_a[10]), 0);
        if (we) begin
            logic [63:0] e;
            chk(sd_dq_oe == 1'b1, "R6", "data enable on write", 64'(sd_dq_oe), 1);
            chk(sd_dq_out == wd, "R6", "write data", sd_dq_out, wd);
            chk(sd_dqm == ~be, "R6", "byte masks", 64'(sd_dqm), 64'(~be));
            e = exp_mem.exists(addr) ? exp_mem[addr] : 64'h0;
            for (int b = 0; b < 8; b++) if (be[b]) e[b*8 +: 8] = wd[b*8 +: 8];
            exp_mem[addr] = e;
        end else begin
            @(negedge clk);
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R7", "response early", 64'(rsp_valid), 0);
            @(negedge clk);
            chk(rsp_valid == 1'b1, "R7", "response 3 cycles after read", 64'(rsp_valid), 1);
            rd = rsp_rdata;
        end
    endtask

    task automatic read_expect(input logic [24:0] addr, input string req);
        logic [63:0] got, e;
        host_req(1'b0, addr, '0, '0, got);
        e = exp_mem.exists(addr) ? exp_mem[addr] : 64'h0;
        chk(got == e, req, "read data", got, e);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        int k = 0;
        repeat (5) @(negedge clk);
        chk(req_ready == 1'b0, "R1", "ready in reset", 64'(req_ready), 0);
        chk(rsp_valid == 1'b0, "R1", "rsp in reset", 64'(rsp_valid), 0);
        chk(sd_cs_n == 1'b1, "R1", "cs_n in reset", 64'(sd_cs_n), 1);
        rst_n = 1'b1;
        do begin @(negedge clk); k++; end while (pin_cmd == C_NOP && k < INIT_CYC + 50);
        chk(k == INIT_CYC, "R1", "power-up wait", 64'(k), INIT_CYC);
        while (pin_cmd != C_MRS && k < INIT_CYC + 100) begin @(negedge clk); k++; end
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after mode set", 64'(req_ready), 1);
        chk(seq_cmd[0] == C_PRE && seq_a[0][10], "R1", "first command precharge-all", 64'(seq_cmd[0]), 64'(C_PRE));
        chk(seq_cmd[1] == C_REF, "R1", "second command refresh", 64'(seq_cmd[1]), 64'(C_REF));
        chk(seq_cmd[2] == C_REF, "R1", "third command refresh", 64'(seq_cmd[2]), 64'(C_REF));
        chk(seq_cmd[3] == C_MRS, "R1", "fourth command mode set", 64'(seq_cmd[3]), 64'(C_MRS));
        chk(seq_a[3] == 13'h020 && seq_ba[3] == 2'b00, "R1", "mode word", 64'(seq_a[3]), 64'h020);
        chk(seq_cyc[1] - seq_cyc[0] >= 2, "R9", "precharge->refresh", 64'(seq_cyc[1] - seq_cyc[0]), 2);
    endtask

    task automatic t_basic();
        logic [63:0] d;
        host_req(1'b1, {2'd0, 13'd0, 10'd0}, 64'h0123_4567_89AB_CDEF, 8'hFF, d);
        host_req(1'b1, 25'h1FF_FFFF, 64'hFEDC_BA98_7654_3210, 8'hFF, d);
        host_req(1'b1, {2'd2, 13'h0AAA, 10'h155}, 64'hA5A5_5A5A_0F0F_F0F0, 8'hFF, d);
        host_req(1'b1, {2'd1, 13'h1555, 10'h2AA}, 64'h0000_0000_0000_0001, 8'hFF, d);
        read_expect({2'd0, 13'd0, 10'd0}, "R7");
        read_expect(25'h1FF_FFFF, "R3");
        read_expect({2'd2, 13'h0AAA, 10'h155}, "R3");
        read_expect({2'd1, 13'h1555, 10'h2AA}, "R7");
        // same column and row, other bank: must stay distinct (R3)
        read_expect({2'd3, 13'h0AAA, 10'h155}, "R3");
    endtask

    task automatic t_mask();
        logic [63:0] d;
        logic [24:0] a = {2'd3, 13'h0123, 10'h3C0};
        host_req(1'b1, a, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, d);
        host_req(1'b1, a, 64'h1122_3344_5566_7788, 8'b0101_0011, d);
        read_expect(a, "R6");
        host_req(1'b1, a, 64'h0, 8'h00, d);
        read_expect(a, "R6");
    endtask

    task automatic t_stress();
        logic [63:0] d;
        for (int i = 0; i < 150; i++) begin
            logic [24:0] a;
            a = 25'(i * 32'h0002_A4C3 + 7);
            host_req(1'b1, a, {32'(i), ~32'(i * 3)}, 8'(8'hFF ^ i[7:0]), d);
            read_expect(a, "R10");
        end
        chk(ref_total >= 4, "R8", "periodic refreshes under load", 64'(ref_total), 4);
    endtask

    // ---------------- main and watchdog ----------------
    initial begin
        t_reset();
        t_basic();
        t_mask();
        t_stress();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule